// File: doc/BRIEF.md
# Receive Frame Buffer Chunker

This block sits between a receive frame stream and the logic that fills receive memory buffers. Frames arrive one byte per cycle with start and end markers. The block decides where each memory buffer begins and ends. It emits one output beat per byte, and each beat carries a chunk start strobe, a chunk end strobe, the running byte count inside the chunk and a tag that marks the beat as header or payload. The chunk size comes from an 8-bit buffer-size field counted in 64-byte units, so a value of 0x18 selects 1536-byte buffers.

When header splitting is on, an upstream parser gives the header length with the first byte of the frame. For a plain untagged frame it reports 14 bytes. The header bytes go into their own buffer or buffers, still cut at the buffer size, and the payload always starts in a fresh buffer. A split frame therefore always uses at least two buffers. If the frame ends at or before the end of its header, the block emits an empty payload chunk on the cycle after the final byte.

An unbounded-last-buffer mode lets the chunk that begins while the ring-last flag is raised take the rest of the frame without size cuts. The final chunk of each frame also carries one status bit. That bit is the FCS error when CRC reporting is selected, and the VLAN CFI bit otherwise.

Top module: `rxs_top`

## Requirements
- R1: With splitting off, a frame is cut into chunks of exactly `buf_units`×64 bytes, and the final chunk holds the remainder. A buffer-size value of zero is illegal while a byte is presented.
- R2: With splitting active, every byte whose 1-based index within the frame is at most the header length has `o_hdr`=1. The chunk ends on the last header byte and also at each full buffer size. The first payload byte opens a new chunk, and a payload beat is never followed by a header beat in the same frame.
- R3: If a split frame ends at or before its header end, one empty chunk follows on the next cycle with `o_beat`=0, `o_start`=`o_end`=`o_last`=1 and `o_cnt`=0. The stream must leave at least one idle cycle after each end-of-frame byte.
- R4: Splitting applies only when `split_en` and `hdr_len_valid` are high and `hdr_len` is nonzero on the start-of-frame byte. Otherwise the frame is chunked as unsplit.
- R5: When `inf_last_en` and `ring_last` are both high on the first byte of a chunk, that chunk is not cut by the buffer size. The header end still cuts it. With `ring_last` low, normal cuts apply.
- R6: Exactly one chunk end per frame carries `o_last`. `o_first` is high on every beat of the first chunk of a frame only.
- R7: On the beat carrying `o_last`, `o_stat` equals `fcs_err` when `crc_rpt_en`=1 and `vlan_cfi` otherwise, using the values sampled with the end-of-frame byte.
- R8: During reset all outputs are zero.
- R9: Each accepted byte yields exactly one `o_beat` on the next cycle. The sum of `o_cnt` over all chunk ends equals the frame length.
- R10: `o_start` marks the first beat of every chunk, with `o_cnt`=1 on that beat, and the number of chunk starts equals the number of chunk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is presented this cycle |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| hdr_len_valid | input | 1 | Header length valid, sampled with the first byte |
| hdr_len | input | HLEN_W | Header length in bytes |
| buf_units | input | SIZE_W | Buffer size in 64-byte units, nonzero |
| split_en | input | 1 | Header/payload splitting enable |
| inf_last_en | input | 1 | Unbounded-last-buffer mode enable |
| ring_last | input | 1 | Next buffer is the last in the list |
| crc_rpt_en | input | 1 | Status bit selects FCS error (1) or VLAN CFI (0) |
| fcs_err | input | 1 | FCS error of the frame, valid with the end byte |
| vlan_cfi | input | 1 | CFI bit of a tagged frame, valid with the end byte |
| o_beat | output | 1 | One output beat per accepted byte |
| o_start | output | 1 | First beat of a chunk |
| o_end | output | 1 | Last beat of a chunk |
| o_hdr | output | 1 | Beat belongs to the header |
| o_first | output | 1 | Beat belongs to the first chunk of the frame |
| o_last | output | 1 | Chunk end is the final one of the frame |
| o_stat | output | 1 | Status bit on the final chunk end |
| o_cnt | output | CNT_W | Byte position within the current chunk |

## Verification
The hardest case to reach from the ports is the empty payload chunk. It needs a split frame whose end byte falls exactly on, or before, the header's last byte, and the chunk then appears on a cycle with no input beat. The stimulus table contains frames of exactly 14 and 54 header bytes and a 30-byte frame against a 54-byte header. The bench samples the idle cycle after each frame's end, so the extra chunk and its status bit are counted. Unbounded chunks are reached by holding `ring_last` high with the mode enabled, and a contrasting frame holds `ring_last` low with the mode still enabled.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef struct packed {
      logic beat;
      logic start;
      logic fin;
      logic hdr;
      logic first;
      logic last;
      logic stat;
   } rxs_flags_t;

   localparam rxs_flags_t RXS_IDLE = '{default: 1'b0};
endpackage

// File: rtl/rxs_cap_calc.sv
module rxs_cap_calc #(
   parameter int SIZE_W    = 8,
   parameter int UNIT_LOG2 = 6,
   parameter int CNT_W     = 16
) (
   input  logic [SIZE_W-1:0] units,
   output logic [CNT_W-1:0]  cap
);
   localparam int CAP_W = SIZE_W + UNIT_LOG2;

   generate
      if (UNIT_LOG2 == 0) begin : g_direct
         assign cap = CNT_W'(units);
      end else begin : g_shift
         logic [CAP_W-1:0] scaled;
         assign scaled = {units, {UNIT_LOG2{1'b0}}};
         assign cap    = CNT_W'(scaled);
      end
   endgenerate
endmodule

// File: rtl/rxs_hdr_track.sv
module rxs_hdr_track #(
   parameter int HLEN_W = 8,
   parameter int FLEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              split_en,
   input  logic              hdr_len_valid,
   input  logic [HLEN_W-1:0] hdr_len,
   output logic              hdr_byte,
   output logic              hdr_last
);
   logic              split_q;
   logic [HLEN_W-1:0] hlen_q;
   logic [FLEN_W-1:0] idx_q;

   logic              act_now;
   logic [HLEN_W-1:0] hlen_now;
   logic [FLEN_W-1:0] idx_now;
   logic [FLEN_W-1:0] hlen_ext;

   always_comb begin
      act_now  = in_sof ? (split_en && hdr_len_valid && (hdr_len != '0)) : split_q;
      hlen_now = in_sof ? hdr_len : hlen_q;
      if (in_sof)
         idx_now = FLEN_W'(1);
      else if (&idx_q)
         idx_now = idx_q;
      else
         idx_now = idx_q + FLEN_W'(1);
      hlen_ext = FLEN_W'(hlen_now);
      hdr_byte = act_now && (idx_now <= hlen_ext);
      hdr_last = act_now && (idx_now == hlen_ext);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         split_q <= 1'b0;
         hlen_q  <= '0;
         idx_q   <= '0;
      end else if (in_valid) begin
         split_q <= act_now;
         hlen_q  <= hlen_now;
         idx_q   <= idx_now;
      end
   end
endmodule

// File: rtl/rxs_stat_sel.sv
module rxs_stat_sel (
   input  logic crc_rpt_en,
   input  logic fcs_err,
   input  logic vlan_cfi,
   output logic stat
);
   assign stat = crc_rpt_en ? fcs_err : vlan_cfi;
endmodule

// File: rtl/rxs_cut_ctrl.sv
module rxs_cut_ctrl
   import rxs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [CNT_W-1:0] cap,
   input  logic             inf_last_en,
   input  logic             ring_last,
   input  logic             hdr_byte,
   input  logic             hdr_last,
   input  logic             stat_in,
   output rxs_flags_t       flags,
   output logic [CNT_W-1:0] cnt
);
   logic             open_q;
   logic [CNT_W-1:0] fill_q;
   logic             unb_q;
   logic             first_q;
   logic             pend_q;
   logic             pend_stat_q;

   logic             start_now;
   logic             unb_now;
   logic [CNT_W-1:0] pos;
   logic             first_now;
   logic             cut_size;
   logic             end_now;
   logic             last_now;
   logic             need_empty;

   always_comb begin
      start_now = in_sof || !open_q;
      unb_now   = start_now ? (inf_last_en && ring_last) : unb_q;
      if (start_now)
         pos = CNT_W'(1);
      else if (&fill_q)
         pos = fill_q;
      else
         pos = fill_q + CNT_W'(1);
      first_now  = in_sof || (!start_now && first_q);
      cut_size   = !unb_now && (pos == cap);
      end_now    = in_eof || cut_size || hdr_last;
      last_now   = in_eof && !hdr_byte;
      need_empty = in_eof && hdr_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q      <= 1'b0;
         fill_q      <= '0;
         unb_q       <= 1'b0;
         first_q     <= 1'b0;
         pend_q      <= 1'b0;
         pend_stat_q <= 1'b0;
         flags       <= RXS_IDLE;
         cnt         <= '0;
      end else if (in_valid) begin
         open_q      <= !end_now;
         fill_q      <= pos;
         unb_q       <= unb_now;
         first_q     <= first_now;
         pend_q      <= need_empty;
         pend_stat_q <= stat_in;
         flags.beat  <= 1'b1;
         flags.start <= start_now;
         flags.fin   <= end_now;
         flags.hdr   <= hdr_byte;
         flags.first <= first_now;
         flags.last  <= last_now;
         flags.stat  <= last_now && stat_in;
         cnt         <= pos;
      end else if (pend_q) begin
         pend_q      <= 1'b0;
         flags.beat  <= 1'b0;
         flags.start <= 1'b1;
         flags.fin   <= 1'b1;
         flags.hdr   <= 1'b0;
         flags.first <= 1'b0;
         flags.last  <= 1'b1;
         flags.stat  <= pend_stat_q;
         cnt         <= '0;
      end else begin
         flags <= RXS_IDLE;
         cnt   <= '0;
      end
   end
endmodule

// File: rtl/rxs_top.sv
module rxs_top
   import rxs_pkg::*;
#(
   parameter int SIZE_W    = 8,
   parameter int UNIT_LOG2 = 6,
   parameter int HLEN_W    = 8,
   parameter int FLEN_W    = 16,
   parameter int CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              hdr_len_valid,
   input  logic [HLEN_W-1:0] hdr_len,
   input  logic [SIZE_W-1:0] buf_units,
   input  logic              split_en,
   input  logic              inf_last_en,
   input  logic              ring_last,
   input  logic              crc_rpt_en,
   input  logic              fcs_err,
   input  logic              vlan_cfi,
   output logic              o_beat,
   output logic              o_start,
   output logic              o_end,
   output logic              o_hdr,
   output logic              o_first,
   output logic              o_last,
   output logic              o_stat,
   output logic [CNT_W-1:0]  o_cnt
);
   localparam int CAP_W = SIZE_W + UNIT_LOG2;

   generate
      if (CNT_W < CAP_W) begin : g_bad_cnt
         $error("rxs_top: CNT_W must hold the largest buffer size");
      end
      if (FLEN_W < HLEN_W) begin : g_bad_flen
         $error("rxs_top: FLEN_W must be at least HLEN_W");
      end
   endgenerate

   logic [CNT_W-1:0] cap;
   logic             hdr_byte;
   logic             hdr_last;
   logic             stat_in;
   rxs_flags_t       flags;

   rxs_cap_calc #(.SIZE_W(SIZE_W), .UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)) u_cap (
      .units (buf_units),
      .cap   (cap)
   );

   rxs_hdr_track #(.HLEN_W(HLEN_W), .FLEN_W(FLEN_W)) u_hdr (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_sof        (in_sof),
      .split_en      (split_en),
      .hdr_len_valid (hdr_len_valid),
      .hdr_len       (hdr_len),
      .hdr_byte      (hdr_byte),
      .hdr_last      (hdr_last)
   );

   rxs_stat_sel u_stat (
      .crc_rpt_en (crc_rpt_en),
      .fcs_err    (fcs_err),
      .vlan_cfi   (vlan_cfi),
      .stat       (stat_in)
   );

   rxs_cut_ctrl #(.CNT_W(CNT_W)) u_cut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sof      (in_sof),
      .in_eof      (in_eof),
      .cap         (cap),
      .inf_last_en (inf_last_en),
      .ring_last   (ring_last),
      .hdr_byte    (hdr_byte),
      .hdr_last    (hdr_last),
      .stat_in     (stat_in),
      .flags       (flags),
      .cnt         (o_cnt)
   );

   assign o_beat  = flags.beat;
   assign o_start = flags.start;
   assign o_end   = flags.fin;
   assign o_hdr   = flags.hdr;
   assign o_first = flags.first;
   assign o_last  = flags.last;
   assign o_stat  = flags.stat;
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
   parameter int SIZE_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_eof,
   input logic [SIZE_W-1:0] buf_units,
   input logic              o_beat,
   input logic              o_start,
   input logic              o_end,
   input logic              o_hdr,
   input logic              o_last,
   input logic [CNT_W-1:0]  o_cnt
);
   // R1
   size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (buf_units != '0));

   // R9
   beat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> o_beat);

   // R6
   last_is_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_last |-> o_end);

   // R3
   empty_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_end && !o_beat) |-> (o_cnt == '0 && o_last && o_start));

   // R3
   eof_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> !in_valid);

   // R2
   pay_stays_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_beat && !o_hdr && !o_end) |=> !o_hdr);

   // R10
   start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_beat && o_start) |-> (o_cnt == CNT_W'(1)));
endmodule

bind rxs_top rxs_chk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_rxs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_eof    (in_eof),
   .buf_units (buf_units),
   .o_beat    (o_beat),
   .o_start   (o_start),
   .o_end     (o_end),
   .o_hdr     (o_hdr),
   .o_last    (o_last),
   .o_cnt     (o_cnt)
);

// File: tb/tb_rxs_top.sv
module tb_rxs_top;
   localparam int CLK_P = 10;
   localparam int NV    = 14;
   // fields: len, units, split, hvalid, hlen, inf, ring_last, exp_ends, exp_last_cnt, exp_hdr_ends
   localparam int VEC [NV][10] = '{
      '{150, 1,    0, 1, 54,  0, 0, 3, 22,  0},
      '{128, 1,    0, 1, 54,  0, 0, 2, 64,  0},
      '{150, 1,    1, 1, 54,  0, 0, 3, 32,  1},
      '{150, 1,    1, 1, 100, 0, 0, 3, 50,  2},
      '{54,  1,    1, 1, 54,  0, 0, 2, 0,   1},
      '{150, 1,    1, 0, 54,  0, 0, 3, 22,  0},
      '{200, 1,    0, 1, 54,  1, 1, 1, 200, 0},
      '{200, 2,    0, 1, 54,  0, 0, 2, 72,  0},
      '{14,  1,    1, 1, 14,  0, 0, 2, 0,   1},
      '{100, 1,    1, 1, 14,  0, 0, 3, 22,  1},
      '{200, 1,    1, 1, 54,  1, 1, 2, 146, 1},
      '{30,  1,    1, 1, 54,  0, 0, 2, 0,   1},
      '{1600, 24,  0, 1, 54,  0, 0, 2, 64,  0},
      '{150, 1,    0, 1, 54,  1, 0, 3, 22,  0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic        hdr_len_valid = 1'b0;
   logic [7:0]  hdr_len = '0;
   logic [7:0]  buf_units = 8'd1;
   logic        split_en = 1'b0, inf_last_en = 1'b0, ring_last = 1'b0;
   logic        crc_rpt_en = 1'b0, fcs_err = 1'b0, vlan_cfi = 1'b0;
   logic        o_beat, o_start, o_end, o_hdr, o_first, o_last, o_stat;
   logic [15:0] o_cnt;

   int checks = 0;
   int errors = 0;
   int n_beat, n_start, n_end, n_hdr_end, n_last, n_first_end, sum_cnt, last_cnt;
   logic stat_seen;

   always #(CLK_P/2) clk = ~clk;

   rxs_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .hdr_len_valid(hdr_len_valid), .hdr_len(hdr_len), .buf_units(buf_units),
      .split_en(split_en), .inf_last_en(inf_last_en), .ring_last(ring_last),
      .crc_rpt_en(crc_rpt_en), .fcs_err(fcs_err), .vlan_cfi(vlan_cfi),
      .o_beat(o_beat), .o_start(o_start), .o_end(o_end), .o_hdr(o_hdr),
      .o_first(o_first), .o_last(o_last), .o_stat(o_stat), .o_cnt(o_cnt)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic tally();
      if (o_beat) n_beat++;
      if (o_start) n_start++;
      if (o_end) begin
         n_end++;
         last_cnt = int'(o_cnt);
         sum_cnt += int'(o_cnt);
         if (o_hdr) n_hdr_end++;
         if (o_first) n_first_end++;
      end
      if (o_last) begin
         n_last++;
         stat_seen = o_stat;
      end
   endtask

   task automatic send(input int len, input int units, input bit sp, input bit hv,
                       input int hl, input bit inf, input bit rl);
      n_beat = 0; n_start = 0; n_end = 0; n_hdr_end = 0;
      n_last = 0; n_first_end = 0; sum_cnt = 0; last_cnt = -1; stat_seen = 1'b0;
      for (int b = 0; b < len; b++) begin
         @(negedge clk);
         in_valid      = 1'b1;
         in_sof        = (b == 0);
         in_eof        = (b == len - 1);
         buf_units     = 8'(units);
         split_en      = sp;
         hdr_len_valid = hv;
         hdr_len       = 8'(hl);
         inf_last_en   = inf;
         ring_last     = rl;
         @(posedge clk);
         #1 tally();
      end
      for (int g = 0; g < 2; g++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
         @(posedge clk);
         #1 tally();
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R8 reset state
      chk({o_beat, o_start, o_end, o_hdr, o_first, o_last, o_stat} == 7'b0 && o_cnt == 16'd0,
          "R8 outputs zero in reset", int'(o_cnt), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         send(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3] != 0, VEC[v][4],
              VEC[v][5] != 0, VEC[v][6] != 0);
         chk(n_end == VEC[v][7], $sformatf("R1 R2 R4 R5 vec%0d chunk ends", v), n_end, VEC[v][7]);
         chk(last_cnt == VEC[v][8], $sformatf("R1 R3 R5 vec%0d final count", v), last_cnt, VEC[v][8]);
         chk(n_hdr_end == VEC[v][9], $sformatf("R2 R4 vec%0d header chunk ends", v), n_hdr_end, VEC[v][9]);
         chk(n_beat == VEC[v][0], $sformatf("R9 vec%0d beats", v), n_beat, VEC[v][0]);
         chk(sum_cnt == VEC[v][0], $sformatf("R9 vec%0d byte sum", v), sum_cnt, VEC[v][0]);
         chk(n_start == n_end, $sformatf("R10 vec%0d starts vs ends", v), n_start, n_end);
         chk(n_last == 1, $sformatf("R6 vec%0d last flags", v), n_last, 1);
         chk(n_first_end == 1, $sformatf("R6 vec%0d first chunk ends", v), n_first_end, 1);
      end

      // R7 status selection on the final chunk
      crc_rpt_en = 1'b1; fcs_err = 1'b1; vlan_cfi = 1'b0;
      send(100, 1, 0, 1, 14, 0, 0);
      chk(stat_seen == 1'b1, "R7 fcs error reported", int'(stat_seen), 1);
      crc_rpt_en = 1'b0; fcs_err = 1'b1; vlan_cfi = 1'b0;
      send(100, 1, 0, 1, 14, 0, 0);
      chk(stat_seen == 1'b0, "R7 cfi selected, fcs ignored", int'(stat_seen), 0);
      crc_rpt_en = 1'b0; fcs_err = 1'b0; vlan_cfi = 1'b1;
      send(54, 1, 1, 1, 54, 0, 0);
      chk(stat_seen == 1'b1, "R7 R3 cfi on empty chunk", int'(stat_seen), 1);
      chk(last_cnt == 0, "R3 empty chunk count", last_cnt, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule